// File: doc/BRIEF.md
# Three-Channel Temperature Threshold Monitor

This block compares three 8-bit temperature readings against two per-channel thresholds: a warning ("high") limit and a more severe over-temperature limit. Each comparison keeps a status flag with hysteresis. A flag goes high once the reading is strictly above its limit. It drops only when the reading is strictly below the limit minus the channel's hysteresis. For all readings in between, the flag keeps its last value. All six flags sit in a live status register.

Two writable byte registers shape the outputs. A beep mask selects which flags may sound `beep_o`. An output mask gates two other outputs per channel: `alert_o`, driven by the warning-level flags, and `ovt_o`, driven by the over-temperature flags.

Software reaches the registers through a plain byte-wide port with an index, a write strobe, write data and combinational read data. Every access completes in one cycle. The block has no stream interface, so there is no valid/ready handshake and no back-pressure. Readings, limits and hysteresis values are level inputs sampled on every clock edge.

Top module: `temp_limit_monitor`

## Requirements
- R1: For each channel, the over-temperature flag is 1 after any clock edge at which that channel's reading was strictly greater than its over-temperature limit. Channel 1 uses bits [7:0] of every packed per-channel input, channel 2 uses [15:8] and channel 3 uses [23:16].
- R2: For each channel, the warning flag is 1 after any clock edge at which the reading was strictly greater than the warning limit.
- R3: A flag is 0 after any clock edge at which the reading was strictly less than (its limit minus the channel hysteresis). That difference saturates at 0, so when the hysteresis is at least the limit, the flag never clears except through reset.
- R4: When a reading is neither above a limit nor below its clear point, the flag keeps its previous value.
- R5: Index 0x62 reads the live flags. Bits 7, 6 and 5 are the over-temperature flags of channels 3, 2 and 1. Bits 3, 2 and 1 are the warning flags of channels 3, 2 and 1. Bits 4 and 0 read 0. All flags are 0 after reset.
- R6: Index 0x63 is the beep mask, with the same bit positions as 0x62. A write takes effect at that clock edge. Bits 4 and 0 always read 0. The register resets to 0.
- R7: Index 0x66 is the output mask. Bits 7, 6 and 5 enable the alert for channels 3, 2 and 1. Bits 3, 2 and 1 enable the over-temperature output for channels 3, 2 and 1. Bits 4 and 0 always read 0. The register resets to 0.
- R8: `beep_o` is 1 exactly when some bit set in 0x62 is also set in 0x63.
- R9: `alert_o` is the OR of each channel's warning flag ANDed with its alert enable. `ovt_o` is the OR of each channel's over-temperature flag ANDed with its over-temperature enable.
- R10: A write to 0x62 changes no register. A read of any index other than 0x62, 0x63 or 0x66 returns 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| temp_i | input | 24 | Packed readings, channel 1 in the low byte |
| high_lim_i | input | 24 | Packed warning limits |
| ovt_lim_i | input | 24 | Packed over-temperature limits |
| hyst_i | input | 24 | Packed per-channel hysteresis |
| reg_idx_i | input | 8 | Register index |
| reg_wr_i | input | 1 | Write strobe |
| reg_wdata_i | input | 8 | Write data |
| reg_rdata_o | output | 8 | Read data for reg_idx_i |
| beep_o | output | 1 | Beep request |
| alert_o | output | 1 | Warning-level alert |
| ovt_o | output | 1 | Over-temperature output |

## Verification
On every cycle, assertions check the set, clear and hold rule of each comparator, the saturation of the clear point, and that writes to the status index leave both masks untouched. They also check that unmapped indices and the reserved bits read zero, and that no output is high without a flag behind it. Only the bench scenarios show the exact bit placement of each channel in the three registers and the per-channel gating of the alert and over-temperature outputs. The same holds for flag sequences that wander around a threshold over many cycles, and for the saturated case where a flag can never clear.

// File: rtl/tlm_pkg.sv
package tlm_pkg;
  localparam int unsigned NCH = 3;
  localparam int unsigned DW  = 8;
  localparam int unsigned RW  = 8;

  localparam logic [RW-1:0] IDX_STATUS = 8'h62;
  localparam logic [RW-1:0] IDX_BEEP   = 8'h63;
  localparam logic [RW-1:0] IDX_OEN    = 8'h66;

  // bit offsets of channel 1 in each field group
  localparam int unsigned OVT_LSB      = 5;
  localparam int unsigned HIGH_LSB     = 1;
  localparam int unsigned ALERT_EN_LSB = 5;
  localparam int unsigned OVT_EN_LSB   = 1;

  // comparator kinds inside one channel
  localparam int unsigned K_HIGH = 0;
  localparam int unsigned K_OVT  = 1;
  localparam int unsigned NK     = 2;

  function automatic logic [RW-1:0] used_mask();
    logic [RW-1:0] m;
    m = '0;
    for (int c = 0; c < NCH; c++) begin
      m[OVT_LSB + c]  = 1'b1;
      m[HIGH_LSB + c] = 1'b1;
    end
    return m;
  endfunction
endpackage

// File: rtl/hyst_cmp.sv
module hyst_cmp #(
  parameter int unsigned W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] sample,
  input  logic [W-1:0] limit,
  input  logic [W-1:0] hyst,
  output logic         flag
);
  logic [W-1:0] clr_pt;
  logic         above;
  logic         below;

  // clear point saturates at zero
  assign clr_pt = (limit > hyst) ? (limit - hyst) : '0;
  assign above  = sample > limit;
  assign below  = sample < clr_pt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     flag <= 1'b0;
    else if (above) flag <= 1'b1;
    else if (below) flag <= 1'b0;
  end

  // R1 R2
  set_above_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (sample > limit) |=> flag);

  // R3
  clear_below_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ((limit > hyst) && (sample < limit - hyst)) |=> !flag);

  // R3
  sat_no_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (flag && (hyst >= limit)) |=> flag);

  // R4
  hold_band_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ((sample <= limit) && (sample >= clr_pt)) |=> $stable(flag));
endmodule

// File: rtl/chan_monitor.sv
module chan_monitor
  import tlm_pkg::*;
#(
  parameter int unsigned W = DW
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [W-1:0]      sample,
  input  logic [NK*W-1:0]   limits,
  input  logic [W-1:0]      hyst,
  output logic [NK-1:0]     flags
);
  for (genvar k = 0; k < NK; k++) begin : g_cmp
    hyst_cmp #(.W(W)) u_cmp (
      .clk    (clk),
      .rst_n  (rst_n),
      .sample (sample),
      .limit  (limits[k*W +: W]),
      .hyst   (hyst),
      .flag   (flags[k])
    );
  end

  // R1 R2: over-temperature limit is not below the warning one -> both set
  both_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ((sample > limits[K_OVT*W +: W]) &&
     (limits[K_OVT*W +: W] >= limits[K_HIGH*W +: W]))
    |=> (flags == {NK{1'b1}}));
endmodule

// File: rtl/tlm_regs.sv
module tlm_regs
  import tlm_pkg::*;
(
  input  logic          clk,
  input  logic          rst_n,
  input  logic [RW-1:0] idx,
  input  logic          wr,
  input  logic [RW-1:0] wdata,
  input  logic [RW-1:0] status,
  output logic [RW-1:0] beep_en,
  output logic [RW-1:0] oen,
  output logic [RW-1:0] rdata
);
  localparam logic [RW-1:0] WMASK = used_mask();

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      beep_en <= '0;
      oen     <= '0;
    end else if (wr) begin
      if (idx == IDX_BEEP) beep_en <= wdata & WMASK;
      if (idx == IDX_OEN)  oen     <= wdata & WMASK;
    end
  end

  always_comb begin
    unique case (idx)
      IDX_STATUS: rdata = status & WMASK;
      IDX_BEEP:   rdata = beep_en;
      IDX_OEN:    rdata = oen;
      default:    rdata = '0;
    endcase
  end

  // R10
  status_wr_inert_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr && idx == IDX_STATUS) |=> ($stable(beep_en) && $stable(oen)));

  // R6 R7
  reserved_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ((beep_en & ~WMASK) == '0) && ((oen & ~WMASK) == '0));
endmodule

// File: rtl/temp_limit_monitor.sv
module temp_limit_monitor
  import tlm_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic [NCH*DW-1:0] temp_i,
  input  logic [NCH*DW-1:0] high_lim_i,
  input  logic [NCH*DW-1:0] ovt_lim_i,
  input  logic [NCH*DW-1:0] hyst_i,
  input  logic [RW-1:0]     reg_idx_i,
  input  logic              reg_wr_i,
  input  logic [RW-1:0]     reg_wdata_i,
  output logic [RW-1:0]     reg_rdata_o,
  output logic              beep_o,
  output logic              alert_o,
  output logic              ovt_o
);
  logic [NCH-1:0] high_f;
  logic [NCH-1:0] ovt_f;
  logic [RW-1:0]  status;
  logic [RW-1:0]  beep_en;
  logic [RW-1:0]  oen;

  for (genvar c = 0; c < NCH; c++) begin : g_ch
    logic [NK-1:0] fl;
    chan_monitor #(.W(DW)) u_ch (
      .clk    (clk),
      .rst_n  (rst_n),
      .sample (temp_i[c*DW +: DW]),
      .limits ({ovt_lim_i[c*DW +: DW], high_lim_i[c*DW +: DW]}),
      .hyst   (hyst_i[c*DW +: DW]),
      .flags  (fl)
    );
    assign high_f[c] = fl[K_HIGH];
    assign ovt_f[c]  = fl[K_OVT];
  end

  always_comb begin
    status = '0;
    for (int c = 0; c < NCH; c++) begin
      status[OVT_LSB + c]  = ovt_f[c];
      status[HIGH_LSB + c] = high_f[c];
    end
  end

  tlm_regs u_regs (
    .clk     (clk),
    .rst_n   (rst_n),
    .idx     (reg_idx_i),
    .wr      (reg_wr_i),
    .wdata   (reg_wdata_i),
    .status  (status),
    .beep_en (beep_en),
    .oen     (oen),
    .rdata   (reg_rdata_o)
  );

  assign beep_o  = |(status & beep_en);
  assign alert_o = |(high_f & oen[ALERT_EN_LSB +: NCH]);
  assign ovt_o   = |(ovt_f & oen[OVT_EN_LSB +: NCH]);

  // R8
  beep_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
    beep_o |-> (reg_idx_i != IDX_STATUS || reg_rdata_o != '0));

  // R9
  alert_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
    alert_o |-> (high_f != '0));

  // R9
  ovt_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ovt_o |-> (ovt_f != '0));

  // R10
  unmapped_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_idx_i != IDX_STATUS && reg_idx_i != IDX_BEEP && reg_idx_i != IDX_OEN)
    |-> (reg_rdata_o == '0));

  // R5 R6 R7
  rsvd_bits_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_rdata_o[4] == 1'b0) && (reg_rdata_o[0] == 1'b0));
endmodule

// File: tb/sim_temp_limit_monitor.sv
module sim_temp_limit_monitor;
  localparam int PERIOD = 10;
  localparam int MAXCYC = 200000;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [23:0] temp_i = '0, high_lim_i = '0, ovt_lim_i = '0, hyst_i = '0;
  logic [7:0]  reg_idx_i = 8'h62, reg_wdata_i = '0;
  logic        reg_wr_i = 1'b0;
  logic [7:0]  reg_rdata_o;
  logic        beep_o, alert_o, ovt_o;

  int n_chk = 0;
  int n_bad = 0;
  bit done = 0;

  // bench model state
  bit       m_high [3];
  bit       m_ovt  [3];
  bit [7:0] m_beep = '0;
  bit [7:0] m_oen  = '0;

  always #(PERIOD/2) clk = ~clk;

  temp_limit_monitor u0 (
    .clk(clk), .rst_n(rst_n), .temp_i(temp_i), .high_lim_i(high_lim_i),
    .ovt_lim_i(ovt_lim_i), .hyst_i(hyst_i), .reg_idx_i(reg_idx_i),
    .reg_wr_i(reg_wr_i), .reg_wdata_i(reg_wdata_i), .reg_rdata_o(reg_rdata_o),
    .beep_o(beep_o), .alert_o(alert_o), .ovt_o(ovt_o)
  );

  function automatic bit next_flag(bit f, bit [7:0] t, bit [7:0] lim, bit [7:0] h);
    bit [7:0] lo;
    lo = (lim > h) ? lim - h : 8'd0;
    if (t > lim) return 1'b1;
    if (t < lo)  return 1'b0;
    return f;
  endfunction

  function automatic bit [7:0] m_status();
    bit [7:0] s;
    s = '0;
    for (int c = 0; c < 3; c++) begin
      s[5 + c] = m_ovt[c];
      s[1 + c] = m_high[c];
    end
    return s;
  endfunction

  function automatic bit [7:0] m_read(bit [7:0] idx);
    case (idx)
      8'h62:   return m_status();
      8'h63:   return m_beep;
      8'h66:   return m_oen;
      default: return 8'h00;
    endcase
  endfunction

  task automatic chk(string req, logic [7:0] act, logic [7:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: got %02h expected %02h", req, act, exp);
    end
  endtask

  task automatic check_all();
    bit [7:0] s;
    bit a, o;
    string rq;
    s = m_status();
    case (reg_idx_i)
      8'h62:   rq = "R1 R2 R3 R4 R5 status read";
      8'h63:   rq = "R6 beep mask read";
      8'h66:   rq = "R7 output mask read";
      default: rq = "R10 unmapped read";
    endcase
    chk(rq, reg_rdata_o, m_read(reg_idx_i));
    a = 0; o = 0;
    for (int c = 0; c < 3; c++) begin
      a |= m_high[c] & m_oen[5 + c];
      o |= m_ovt[c]  & m_oen[1 + c];
    end
    chk("R8 beep_o", {7'd0, beep_o}, {7'd0, |(s & m_beep)});
    chk("R9 alert_o", {7'd0, alert_o}, {7'd0, a});
    chk("R9 ovt_o", {7'd0, ovt_o}, {7'd0, o});
  endtask

  task automatic step(bit [23:0] t, bit [23:0] hl, bit [23:0] ol, bit [23:0] hy,
                      bit [7:0] idx, bit wr, bit [7:0] wd);
    bit nh [3];
    bit no [3];
    @(negedge clk);
    temp_i = t; high_lim_i = hl; ovt_lim_i = ol; hyst_i = hy;
    reg_idx_i = idx; reg_wr_i = wr; reg_wdata_i = wd;
    for (int c = 0; c < 3; c++) begin
      nh[c] = next_flag(m_high[c], t[c*8 +: 8], hl[c*8 +: 8], hy[c*8 +: 8]);
      no[c] = next_flag(m_ovt[c],  t[c*8 +: 8], ol[c*8 +: 8], hy[c*8 +: 8]);
    end
    @(posedge clk);
    #1;
    for (int c = 0; c < 3; c++) begin
      m_high[c] = nh[c];
      m_ovt[c]  = no[c];
    end
    if (wr && idx == 8'h63) m_beep = wd & 8'hEE;
    if (wr && idx == 8'h66) m_oen  = wd & 8'hEE;
    check_all();
    reg_wr_i = 1'b0;
  endtask

  initial begin : watchdog
    repeat (MAXCYC) @(posedge clk);
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  end

  initial begin : main
    bit [23:0] hl, ol, hy, t;
    bit [7:0]  ix;
    int unsigned r;
    r = $urandom(32'd1234);
    for (int c = 0; c < 3; c++) begin m_high[c] = 0; m_ovt[c] = 0; end
    hl = {8'd80, 8'd80, 8'd80};
    ol = {8'd100, 8'd100, 8'd100};
    hy = {8'd5, 8'd5, 8'd5};
    temp_i = {8'd120, 8'd120, 8'd120};
    high_lim_i = hl; ovt_lim_i = ol; hyst_i = hy;
    repeat (3) @(posedge clk);
    #1;
    // R5 R6 R7: reset state, hot readings ignored while in reset
    reg_idx_i = 8'h62; #1; chk("R5 reset status", reg_rdata_o, 8'h00);
    reg_idx_i = 8'h63; #1; chk("R6 reset beep mask", reg_rdata_o, 8'h00);
    reg_idx_i = 8'h66; #1; chk("R7 reset output mask", reg_rdata_o, 8'h00);
    chk("R8 R9 reset outputs", {5'd0, beep_o, alert_o, ovt_o}, 8'h00);
    @(negedge clk); rst_n = 1'b1;

    // directed: masks with reserved bits written as ones
    step(24'h0, hl, ol, hy, 8'h63, 1, 8'hFF);   // R6 reads EE
    step(24'h0, hl, ol, hy, 8'h66, 1, 8'hFF);   // R7 reads EE
    // R1 R2: channel 2 only over both limits
    step({8'd50, 8'd101, 8'd50}, hl, ol, hy, 8'h62, 0, 8'h00);
    // R10: writing status changes nothing
    step({8'd50, 8'd101, 8'd50}, hl, ol, hy, 8'h62, 1, 8'h00);
    step({8'd50, 8'd101, 8'd50}, hl, ol, hy, 8'h63, 0, 8'h00);
    step({8'd50, 8'd101, 8'd50}, hl, ol, hy, 8'h66, 0, 8'h00);
    step({8'd50, 8'd101, 8'd50}, hl, ol, hy, 8'h64, 1, 8'hFF);  // R10 unmapped
    // R4: equal to limit holds, equal to clear point holds
    step({8'd50, 8'd100, 8'd50}, hl, ol, hy, 8'h62, 0, 8'h00);
    step({8'd50, 8'd95, 8'd50},  hl, ol, hy, 8'h62, 0, 8'h00);
    // R3: just below clear point drops OVT, warning stays
    step({8'd50, 8'd94, 8'd50},  hl, ol, hy, 8'h62, 0, 8'h00);
    // R9: mask only channel 3 alert / channel 1 OVT enable
    step({8'd50, 8'd94, 8'd50},  hl, ol, hy, 8'h66, 1, 8'h82);
    step({8'd101, 8'd94, 8'd50}, hl, ol, hy, 8'h62, 0, 8'h00);
    step({8'd50, 8'd94, 8'd101}, hl, ol, hy, 8'h62, 0, 8'h00);
    // R3 saturation: channel 1 limit 3, hysteresis 10, never clears
    step({8'd50, 8'd50, 8'd4}, {hl[23:8], 8'd3}, ol, {hy[23:8], 8'd10}, 8'h62, 0, 8'h00);
    step({8'd50, 8'd50, 8'd0}, {hl[23:8], 8'd3}, ol, {hy[23:8], 8'd10}, 8'h62, 0, 8'h00);
    step({8'd50, 8'd50, 8'd0}, {hl[23:8], 8'd3}, ol, {hy[23:8], 8'd10}, 8'h62, 0, 8'h00);

    // constrained random near the thresholds
    for (int i = 0; i < 3000; i++) begin
      if (i % 500 == 0) begin
        for (int c = 0; c < 3; c++) begin
          hl[c*8 +: 8] = 8'($urandom_range(40, 120));
          ol[c*8 +: 8] = 8'($urandom_range(40, 200));
          hy[c*8 +: 8] = 8'($urandom_range(0, 30));
        end
      end
      for (int c = 0; c < 3; c++) t[c*8 +: 8] = 8'($urandom_range(20, 220));
      case ($urandom_range(0, 5))
        0, 1, 2: ix = 8'h62;
        3:       ix = 8'h63;
        4:       ix = 8'h66;
        default: ix = 8'($urandom_range(0, 255));
      endcase
      step(t, hl, ol, hy, ix, ($urandom_range(0, 3) == 0), 8'($urandom_range(0, 255)));
    end

    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule